// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over software with a 7-bit down-counter that must be reloaded inside a time window. A prescaler divides the bus clock by a base divisor and then by 1, 2, 4 or 8, and each prescaled tick moves the counter down by one once the watchdog is armed. Software reloads the counter by writing the control register. If the reload comes too late, the counter falls from 0x40 to 0x3F and a system-reset request fires. If the reload comes too early, while the counter is still above the programmed window value, a reset request also fires. When the counter reaches 0x40, an early-warning flag is set. This flag can raise an interrupt, which gives software a last chance to reload.

The block comes out of reset disarmed. Once software arms it, the arm bit cannot be cleared except by a system reset. A debug-halt input can stop the prescaler and counter, but only when the freeze-enable input is set.

Registers are at byte offsets 0x0 (control), 0x4 (configuration) and 0x8 (status). A read returns its data in the cycle after the read strobe.

Top module: `window_watchdog`

## Requirements
- R1: After reset the block is disarmed and all of its state is at known values:
  - control reads 0x7F, meaning arm is clear and the counter is 0x7F.
  - configuration reads 0x07F, meaning the window is 0x7F, the timebase is 0 and the interrupt enable is 0.
  - status reads 0.
  - `sys_rst_req` and `ew_irq` are low.
  - While disarmed, the counter does not move.
- R2: The control register has arm at bit 7 and the counter at bits 6:0. A read returns the live counter. A write always loads bits 6:0 into the counter.
- R3: Writing 1 to arm sets it. Writing 0 to arm leaves it unchanged. Arm stays set until reset.
- R4: While armed, each tick decrements the counter. A tick occurs every PRE_DIV×2^tb bus clocks, counted from the last control write. The configuration register has the window at bits 6:0, the timebase tb at bits 8:7 and the interrupt enable at bit 9.
- R5: While armed, a control write that arrives when the counter is above the window raises `sys_rst_req` for exactly one cycle, starting in the cycle after the write.
- R6: While armed, a control write whose bit 6 is 0 raises `sys_rst_req` for one cycle.
- R7: A tick that moves the counter from 0x40 to 0x3F raises `sys_rst_req` for one cycle.
- R8: The early-warning flag is status bit 0. It is set when a tick brings the counter to 0x40. Writing 0 to it clears it. Writing 1 to it has no effect.
- R9: `ew_irq` is high exactly while the flag is set and the interrupt enable is set.
- R10: While `dbg_halt` and `halt_freeze_en` are both high, the prescaler and counter hold their values. `dbg_halt` alone does not stop them.
- R11: A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| dbg_halt | input | 1 | Processor debug-halt indication |
| halt_freeze_en | input | 1 | Lets `dbg_halt` stop the watchdog |
| sys_rst_req | output | 1 | One-cycle system-reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
A counter or prescaler that runs off by a tick shows up in the control read-back, and it also shifts when the flag and the reset pulse appear, by PRE_DIV×2^tb clocks. The bench freezes the block through the debug-halt path. It then releases the block for exact edge counts, so every read-back and pulse check falls on a known cycle. A wrong window comparison or a wrong arm bit shows up as a reset pulse that is present or missing in the first cycle after the control write. A flag that is set or cleared wrongly shows up on `ew_irq` in that same cycle.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int CNT_W = 7;
  localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
  localparam logic [CNT_W-1:0] WARN_VAL  = 7'h40;
  localparam logic [CNT_W-1:0] WIN_INIT  = 7'h7F;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CFG  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;

  typedef struct packed {
    logic             ew_en;
    logic [1:0]       tb;
    logic [CNT_W-1:0] win;
  } cfg_t;
endpackage

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale #(
  parameter int PRE_DIV = 4096,
  parameter int TB_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [TB_W-1:0] tb,
  output logic            tick
);
  localparam int NSEL  = 2 ** TB_W;
  localparam int PRE_W = $clog2(PRE_DIV) + NSEL - 1;

  logic [PRE_W-1:0] lim_m1 [NSEL];
  logic [PRE_W-1:0] div_q;
  logic             hit;

  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    assign lim_m1[i] = PRE_W'((PRE_DIV << i) - 1);
  end

  assign hit  = (div_q == lim_m1[tb]);
  assign tick = run & hit;

  always_ff @(posedge clk) begin
    if (rst)        div_q <= '0;
    else if (clr)   div_q <= '0;
    else if (run)   div_q <= hit ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             wr_arm,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             stat_wr,
  input  logic             wr_flag,
  input  logic             tick,
  input  logic [CNT_W-1:0] win,
  output logic             act_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             rst_req_q
);
  logic early_bad;
  logic value_bad;
  logic underflow;
  logic warn_set;

  assign early_bad = act_q & (cnt_q > win);
  assign value_bad = act_q & ~wr_cnt[CNT_W-1];
  assign underflow = ~ctrl_wr & tick & (cnt_q == WARN_VAL);
  assign warn_set  = ~ctrl_wr & tick & (cnt_q == WARN_VAL + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      cnt_q     <= CNT_INIT;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= underflow | (ctrl_wr & (early_bad | value_bad));
      if (ctrl_wr) begin
        act_q <= act_q | wr_arm;
        cnt_q <= wr_cnt;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      flag_q <= 1'b0;
    else if (warn_set)            flag_q <= 1'b1;
    else if (stat_wr && !wr_flag) flag_q <= 1'b0;
  end
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              act,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic              ctrl_wr,
  output logic              stat_wr,
  output cfg_t              cfg_q,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CFG_W = $bits(cfg_t);

  logic sel_ctrl, sel_cfg, sel_stat;
  logic unused_hi;

  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cfg   = (bus_addr == ADDR_W'(OFS_CFG));
  assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign ctrl_wr   = bus_wr & sel_ctrl;
  assign stat_wr   = bus_wr & sel_stat;
  assign unused_hi = ^bus_wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{ew_en: 1'b0, tb: 2'd0, win: WIN_INIT};
    end else if (bus_wr && sel_cfg) begin
      cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_ctrl)      bus_rdata <= DATA_W'({act, cnt});
      else if (sel_cfg)  bus_rdata <= DATA_W'(cfg_q);
      else if (sel_stat) bus_rdata <= DATA_W'(flag);
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/window_watchdog.sv
`timescale 1ns/1ps
module window_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int PRE_DIV = 4096,
  parameter int TB_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  input  logic              halt_freeze_en,
  output logic              sys_rst_req,
  output logic              ew_irq
);
  logic             ctrl_wr, stat_wr, tick, run;
  logic             act_q, flag_q;
  logic [CNT_W-1:0] cnt_q;
  cfg_t             cfg_q;

  assign run    = act_q & ~(dbg_halt & halt_freeze_en);
  assign ew_irq = flag_q & cfg_q.ew_en;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .act(act_q), .cnt(cnt_q),
    .flag(flag_q), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .cfg_q(cfg_q),
    .bus_rdata(bus_rdata)
  );

  wdt_prescale #(.PRE_DIV(PRE_DIV), .TB_W(TB_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clr(ctrl_wr), .tb(cfg_q.tb),
    .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_arm(bus_wdata[CNT_W]),
    .wr_cnt(bus_wdata[CNT_W-1:0]), .stat_wr(stat_wr), .wr_flag(bus_wdata[0]),
    .tick(tick), .win(cfg_q.win), .act_q(act_q), .cnt_q(cnt_q),
    .flag_q(flag_q), .rst_req_q(sys_rst_req)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             act,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             tick,
  input logic             ctrl_wr,
  input logic             halt,
  input logic             frz_en,
  input logic [CNT_W-1:0] win,
  input logic             rst_req
);
  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    act |=> act);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!act && !ctrl_wr) |=> $stable(cnt));
  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && frz_en && !ctrl_wr) |=> $stable(cnt));
  // R7
  underflow_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctrl_wr && cnt == WARN_VAL) |=> rst_req);
  // R5
  early_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && act && cnt > win) |=> rst_req);
  // R8
  warn_value_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> cnt == WARN_VAL);
  // R1
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(act));
endmodule

bind window_watchdog wdt_checker u_chk (
  .clk(clk), .rst(rst), .act(act_q), .cnt(cnt_q), .flag(flag_q),
  .tick(tick), .ctrl_wr(ctrl_wr), .halt(dbg_halt), .frz_en(halt_freeze_en),
  .win(cfg_q.win), .rst_req(sys_rst_req)
);

// File: tb/sim_window_watchdog.sv
`timescale 1ns/1ps
module sim_window_watchdog;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          dbg_halt = 1'b0;
  logic          halt_freeze_en = 1'b0;
  logic          sys_rst_req;
  logic          ew_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic rd_pend = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  window_watchdog #(.ADDR_W(AW), .DATA_W(DW), .PRE_DIV(4), .TB_W(2)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .halt_freeze_en(halt_freeze_en),
    .sys_rst_req(sys_rst_req), .ew_irq(ew_irq)
  );

  always @(posedge clk) rd_pend <= bus_rd;

  // monitor: pop the expected read data and compare
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  // release the debug halt for exactly n rising edges, then freeze again
  task automatic run_edges(input int n);
    @(negedge clk);
    dbg_halt = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    dbg_halt = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sys_rst_req, 1'b0, "R1 rst_req after reset");
    chk(ew_irq, 1'b0, "R1 irq after reset");
    rd(4'h0, 32'h7F, "R1 ctrl");
    rd(4'h4, 32'h07F, "R1 cfg");
    rd(4'h8, 32'h0, "R1 status");
    repeat (100) @(posedge clk);
    rd(4'h0, 32'h7F, "R1 idle counter");
    rd(4'hC, 32'h0, "R11 unmapped");
    // R10 freeze with arm write
    @(negedge clk);
    halt_freeze_en = 1'b1; dbg_halt = 1'b1;
    wr(4'h0, 32'hFF);
    repeat (50) @(posedge clk);
    rd(4'h0, 32'hFF, "R10 frozen counter");
    // R4 ten ticks at divisor 4
    run_edges(40);
    rd(4'h0, 32'hF5, "R4 ten ticks");
    // R3 arm cannot be cleared, R2 load
    wr(4'h0, 32'h70);
    chk(sys_rst_req, 1'b0, "R6 legal reload");
    rd(4'h0, 32'hF0, "R3 arm sticky");
    // R5 early refresh
    wr(4'h4, 32'h250);
    rd(4'h4, 32'h250, "R4 cfg layout");
    wr(4'h0, 32'hE0);
    chk(sys_rst_req, 1'b1, "R5 early refresh pulse");
    @(negedge clk);
    chk(sys_rst_req, 1'b0, "R5 pulse one cycle");
    rd(4'h0, 32'hE0, "R2 loaded anyway");
    // R6 reload without bit 6
    wr(4'h4, 32'h27F);
    wr(4'h0, 32'h3A);
    chk(sys_rst_req, 1'b1, "R6 bit6 clear pulse");
    rd(4'h0, 32'hBA, "R2 ctrl readback");
    wr(4'h0, 32'hC8);
    chk(sys_rst_req, 1'b0, "R5 inside window");
    // R8 / R9 early warning
    run_edges(32);
    chk(ew_irq, 1'b1, "R9 irq on warn");
    chk(sys_rst_req, 1'b0, "R7 no reset at 0x40");
    rd(4'h8, 32'h1, "R8 flag set");
    wr(4'h4, 32'h07F);
    chk(ew_irq, 1'b0, "R9 irq masked");
    rd(4'h8, 32'h1, "R8 flag kept while masked");
    wr(4'h4, 32'h27F);
    chk(ew_irq, 1'b1, "R9 irq unmasked");
    wr(4'h8, 32'h1);
    rd(4'h8, 32'h1, "R8 write one ignored");
    wr(4'h8, 32'h0);
    rd(4'h8, 32'h0, "R8 write zero clears");
    chk(ew_irq, 1'b0, "R9 irq after clear");
    // R7 underflow
    run_edges(3);
    chk(sys_rst_req, 1'b0, "R7 before underflow");
    run_edges(1);
    chk(sys_rst_req, 1'b1, "R7 underflow pulse");
    @(negedge clk);
    chk(sys_rst_req, 1'b0, "R7 pulse one cycle");
    rd(4'h0, 32'hBF, "R7 counter 0x3F");
    // R4 timebase 3 -> period 32
    wr(4'h4, 32'h1FF);
    wr(4'h0, 32'hFF);
    chk(sys_rst_req, 1'b0, "R5 reload below window");
    run_edges(31);
    rd(4'h0, 32'hFF, "R4 no tick before 32");
    run_edges(1);
    rd(4'h0, 32'hFE, "R4 tick at 32");
    run_edges(32);
    rd(4'h0, 32'hFD, "R4 second tick");
    // R10 halt without freeze enable keeps running
    @(negedge clk);
    halt_freeze_en = 1'b0;
    repeat (64) @(posedge clk);
    @(negedge clk);
    halt_freeze_en = 1'b1;
    rd(4'h0, 32'hFB, "R10 halt alone runs");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end
endmodule